// File: doc/BRIEF.md
# Video Line and Frame Timing Generator

This block takes the system clock and produces the scanline and frame timing for a video output. A cycle counter splits the clock into scanlines, and a line counter groups those scanlines into frames. The number of cycles in a line and the number of lines in a frame both depend on the video standard in use, which is either 60 Hz or 50 Hz. The block sends out three one-cycle pulses: one per scanline, one when vertical blanking begins, and one at the end of each frame.

The block also keeps a small status set. It holds a per-line parity flag, which vertical blanking start clears. It holds a field bit and a companion bit that is inverted by the field value on every interlaced frame end. It keeps a running frame count, and it shows the video standard currently in use. The standard-select input is only sampled at a frame boundary, so a frame never mixes two timings. Timers, the display controller and the pixel path use these pulses. They are not part of this block.

Top module: `video_timing_gen`

## Requirements
- R1: After reset, the cycle, line and frame counters are zero, all pulses and status bits are low, and the active standard is 60 Hz (`std_active_o` = 0).
- R2: `line_pulse_o` is high for exactly one clock, in the clock after the cycle counter reaches the last cycle of a line. A line is `CYC_60` cycles long in the 60 Hz standard and `CYC_50` cycles long in the 50 Hz standard.
- R3: Each line pulse advances `line_cnt_o` by one. When the line count would reach the frame total (`LINES_60` for 60 Hz, `LINES_50` for 50 Hz), it returns to 0 instead, and `frame_end_o` is high in that same clock.
- R4: `vblank_start_o` is high for one clock, in the clock where `line_cnt_o` has just become `VBLANK_LINE`.
- R5: `line_parity_o` toggles on every line pulse. It is forced to 0 on the line pulse that starts vertical blanking.
- R6: On a frame end with `interlace_i` = 1, the field value is bit 0 of the frame count before that frame end. `field_o` takes this value, and `field_alt_o` is XORed with it.
- R7: On a frame end with `interlace_i` = 0, and at any time other than a frame end, `field_o` and `field_alt_o` keep their values.
- R8: `std_i` (0 = 60 Hz, 1 = 50 Hz) is loaded into `std_active_o` only on a frame end. A change in the middle of a frame leaves the current frame's timing unchanged.
- R9: `frame_cnt_o` increases by one on every frame end, wrapping modulo 2^`FRAME_W`, and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std_i | input | 1 | Requested standard: 0 = 60 Hz, 1 = 50 Hz |
| interlace_i | input | 1 | Interlaced output enabled |
| line_pulse_o | output | 1 | One-clock pulse per scanline |
| vblank_start_o | output | 1 | One-clock pulse at vertical blanking start |
| frame_end_o | output | 1 | One-clock pulse at frame end |
| line_cnt_o | output | LW | Current scanline number |
| frame_cnt_o | output | FRAME_W | Running frame count |
| std_active_o | output | 1 | Standard currently in use |
| line_parity_o | output | 1 | Per-line parity flag |
| field_o | output | 1 | Interlace field bit |
| field_alt_o | output | 1 | Companion bit, inverted by the field value |

## Verification
The bench builds the block with very short timings: 5 and 7 cycles per line, 10 and 12 lines per frame, and blanking at line 6. At these sizes a full frame lasts only 50 or 84 clocks. This lets the bench cover many frame ends, mid-frame standard switches in both directions, and interlaced runs that alternate the field bit across both standards. It also covers the non-interlaced hold, and the boundary where the vertical blanking line is followed by the frame wrap.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic {
    STD_60 = 1'b0,
    STD_50 = 1'b1
  } vid_std_e;
endpackage

// File: rtl/vtg_cycle_cnt.sv
module vtg_cycle_cnt
  import vtg_pkg::*;
#(
  parameter int CYC_60 = 2146,
  parameter int CYC_50 = 2157
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  vid_std_e std_i,
  output logic     wrap_o,
  output logic     pulse_o
);
  localparam int MAXC = (CYC_60 > CYC_50) ? CYC_60 : CYC_50;
  localparam int CW   = $clog2(MAXC);

  logic [CW-1:0] cyc_q;
  logic [CW-1:0] last_cyc;

  assign last_cyc = (std_i == STD_50) ? CW'(CYC_50 - 1) : CW'(CYC_60 - 1);
  assign wrap_o   = (cyc_q == last_cyc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      cyc_q   <= wrap_o ? '0 : cyc_q + 1'b1;
      pulse_o <= wrap_o;
    end
  end

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R2
  AST_CYC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> cyc_q == '0); // R2
endmodule

// File: rtl/vtg_line_cnt.sv
module vtg_line_cnt
  import vtg_pkg::*;
#(
  parameter int LINES_60    = 263,
  parameter int LINES_50    = 314,
  parameter int VBLANK_LINE = 240,
  parameter int LW          = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  vid_std_e      std_i,
  input  logic          step_i,
  output logic [LW-1:0] line_o,
  output logic          frame_wrap_o,
  output logic          vb_hit_o,
  output logic          vblank_o,
  output logic          frame_end_o
);
  logic [LW-1:0] last_line;
  logic [LW-1:0] line_nxt;

  assign last_line    = (std_i == STD_50) ? LW'(LINES_50 - 1) : LW'(LINES_60 - 1);
  assign frame_wrap_o = step_i && (line_o == last_line);
  assign line_nxt     = line_o + 1'b1;
  assign vb_hit_o     = step_i && !frame_wrap_o && (line_nxt == LW'(VBLANK_LINE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o      <= '0;
      vblank_o    <= 1'b0;
      frame_end_o <= 1'b0;
    end else begin
      if (step_i) line_o <= frame_wrap_o ? '0 : line_nxt;
      vblank_o    <= vb_hit_o;
      frame_end_o <= frame_wrap_o;
    end
  end

  AST_VBLANK_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_o |-> line_o == LW'(VBLANK_LINE)); // R4
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(line_o)); // R3
endmodule

// File: rtl/vtg_frame_ctl.sv
module vtg_frame_ctl
  import vtg_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               std_i,
  input  logic               interlace_i,
  input  logic               step_i,
  input  logic               vb_hit_i,
  input  logic               frame_wrap_i,
  output vid_std_e           std_o,
  output logic [FRAME_W-1:0] frame_cnt_o,
  output logic               parity_o,
  output logic               field_o,
  output logic               field_alt_o
);
  logic fld;
  assign fld = frame_cnt_o[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      std_o       <= STD_60;
      frame_cnt_o <= '0;
      parity_o    <= 1'b0;
      field_o     <= 1'b0;
      field_alt_o <= 1'b0;
    end else begin
      if (step_i) parity_o <= vb_hit_i ? 1'b0 : ~parity_o;
      if (frame_wrap_i) begin
        std_o       <= vid_std_e'(std_i);
        frame_cnt_o <= frame_cnt_o + 1'b1;
        if (interlace_i) begin
          field_o     <= fld;
          field_alt_o <= field_alt_o ^ fld;
        end
      end
    end
  end

  AST_STD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_wrap_i |=> $stable(std_o)); // R8
  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_wrap_i && interlace_i) |=> $stable(field_o) && $stable(field_alt_o)); // R7
  AST_FRAME_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_wrap_i |=> frame_cnt_o == $past(frame_cnt_o) + 1'b1); // R9
  AST_PARITY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vb_hit_i |=> !parity_o); // R5
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int CYC_60      = 2146,
  parameter int CYC_50      = 2157,
  parameter int LINES_60    = 263,
  parameter int LINES_50    = 314,
  parameter int VBLANK_LINE = 240,
  parameter int FRAME_W     = 16,
  localparam int MAXL       = (LINES_60 > LINES_50) ? LINES_60 : LINES_50,
  localparam int LW         = $clog2(MAXL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               std_i,
  input  logic               interlace_i,
  output logic               line_pulse_o,
  output logic               vblank_start_o,
  output logic               frame_end_o,
  output logic [LW-1:0]      line_cnt_o,
  output logic [FRAME_W-1:0] frame_cnt_o,
  output logic               std_active_o,
  output logic               line_parity_o,
  output logic               field_o,
  output logic               field_alt_o
);
  vid_std_e std_q;
  logic     line_wrap;
  logic     frame_wrap;
  logic     vb_hit;

  assign std_active_o = std_q;

  vtg_cycle_cnt #(.CYC_60(CYC_60), .CYC_50(CYC_50)) i_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .std_i   (std_q),
    .wrap_o  (line_wrap),
    .pulse_o (line_pulse_o)
  );

  vtg_line_cnt #(
    .LINES_60(LINES_60), .LINES_50(LINES_50),
    .VBLANK_LINE(VBLANK_LINE), .LW(LW)
  ) i_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .std_i        (std_q),
    .step_i       (line_wrap),
    .line_o       (line_cnt_o),
    .frame_wrap_o (frame_wrap),
    .vb_hit_o     (vb_hit),
    .vblank_o     (vblank_start_o),
    .frame_end_o  (frame_end_o)
  );

  vtg_frame_ctl #(.FRAME_W(FRAME_W)) i_frm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .std_i        (std_i),
    .interlace_i  (interlace_i),
    .step_i       (line_wrap),
    .vb_hit_i     (vb_hit),
    .frame_wrap_i (frame_wrap),
    .std_o        (std_q),
    .frame_cnt_o  (frame_cnt_o),
    .parity_o     (line_parity_o),
    .field_o      (field_o),
    .field_alt_o  (field_alt_o)
  );

  AST_FRAME_END_AT_LINE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> line_pulse_o && line_cnt_o == '0); // R3
  AST_VBLANK_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_start_o |-> line_pulse_o && !frame_end_o); // R4
endmodule

// File: tb/test_video_timing_gen.sv
module test_video_timing_gen;
  localparam int C60 = 5, C50 = 7, L60 = 10, L50 = 12, VB = 6, FW = 8;
  localparam int LW = $clog2(L50);

  logic clk = 1'b0, rst_n = 1'b0, std = 1'b0, ilace = 1'b0;
  logic lp, vbs, fe, act, par, fld, alt;
  logic [LW-1:0] lcnt;
  logic [FW-1:0] fcnt;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  video_timing_gen #(.CYC_60(C60), .CYC_50(C50), .LINES_60(L60), .LINES_50(L50),
                     .VBLANK_LINE(VB), .FRAME_W(FW)) i_video_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .std_i(std), .interlace_i(ilace),
    .line_pulse_o(lp), .vblank_start_o(vbs), .frame_end_o(fe),
    .line_cnt_o(lcnt), .frame_cnt_o(fcnt), .std_active_o(act),
    .line_parity_o(par), .field_o(fld), .field_alt_o(alt));

  // behavioural reference
  int m_cyc = 0, m_line = 0, m_frame = 0, m_std = 0;
  int m_lp = 0, m_vb = 0, m_fe = 0, m_par = 0, m_fld = 0, m_alt = 0;
  int frames_seen = 0;

  always @(posedge clk) if (rst_n) begin
    int ct, lt;
    ct = m_std ? C50 : C60;
    lt = m_std ? L50 : L60;
    m_lp = 0; m_vb = 0; m_fe = 0;
    if (m_cyc == ct - 1) begin
      m_cyc = 0; m_lp = 1;
      if (m_line == lt - 1) begin
        m_line = 0; m_fe = 1; m_par = 1 - m_par;
        if (ilace) begin m_fld = m_frame % 2; m_alt = m_alt ^ m_fld; end
        m_frame = (m_frame + 1) % (1 << FW);
        m_std = std;
        frames_seen++;
      end else begin
        m_line++;
        if (m_line == VB) begin m_vb = 1; m_par = 0; end
        else m_par = 1 - m_par;
      end
    end else m_cyc++;
  end

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act_v, exp_v);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 line_pulse", lp, m_lp);
    chk("R3 line_cnt", lcnt, m_line);
    chk("R3 frame_end", fe, m_fe);
    chk("R4 vblank_start", vbs, m_vb);
    chk("R5 parity", par, m_par);
    chk(ilace ? "R6 field" : "R7 field", fld, m_fld);
    chk(ilace ? "R6 field_alt" : "R7 field_alt", alt, m_alt);
    chk("R8 std_active", act, m_std);
    chk("R9 frame_cnt", fcnt, m_frame);
  end

  task automatic wait_frames(input int n);
    int tgt;
    tgt = frames_seen + n;
    while (frames_seen < tgt) @(negedge clk);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cycles(3);
    // R1 reset state
    chk("R1 line_cnt", lcnt, 0);
    chk("R1 frame_cnt", fcnt, 0);
    chk("R1 pulses", {lp, vbs, fe}, 0);
    chk("R1 status", {act, par, fld, alt}, 0);
    rst_n = 1'b1;
    std = 1'b1;            // R8: mid-frame request, must wait for boundary
    wait_cycles(20);
    wait_frames(1);
    std = 1'b0;            // R7: non-interlaced frames at 50 Hz
    wait_cycles(37);
    std = 1'b1;
    ilace = 1'b1;          // R6: interlaced, several frames both standards
    wait_frames(4);
    wait_cycles(90);
    std = 1'b0;
    wait_frames(3);
    ilace = 1'b0;          // R7 hold after interlace
    wait_frames(2);
    wait_cycles(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule